// File: doc/BRIEF.md
# Dual-Format Stereo Serial Audio Receiver

This block takes a three-wire stereo PCM stream (a bit clock, a frame clock that marks the channel, and a data line) and turns it into parallel left and right samples of up to 24 bits. It runs in the system clock domain. The three serial lines are oversampled through two-flop synchronisers, and edge detection finds each rising edge of the bit clock. A static format input selects one of two framings. In I2S framing the channel change takes effect one bit after the frame clock toggles. In left-justified framing it takes effect at once.

A state machine with three states follows the frame. `ST_HUNT` waits after reset for the first left slot to begin. `ST_LEFT` collects the left slot. `ST_RIGHT` collects the right slot. Three transitions move between them. `T_LOCK` (from `ST_HUNT` to `ST_LEFT`) fires at the first slot boundary that opens a left slot. `T_L2R` (from `ST_LEFT` to `ST_RIGHT`) saves the finished left word. `T_R2L` (from `ST_RIGHT` to `ST_LEFT`) closes the frame. On `T_R2L` the pair is published with a one-cycle strobe. In left-justified mode, a frame shorter than the required number of bit clocks is reported on a separate error strobe instead.

Top module: `serial_audio_rx`

## Requirements
- R1: `fmt_lj` = 0 selects I2S framing and `fmt_lj` = 1 selects left-justified framing. The left channel is carried while `fclk_i` is low in I2S and while `fclk_i` is high in left-justified mode.
- R2: Data is taken on rising edges of `bclk_i`. A slot's MSB is the bit on the second rising edge after a `fclk_i` transition in I2S and on the first rising edge in left-justified mode. In I2S, the bit on the first rising edge belongs to the previous slot.
- R3: Each slot is MSB first and two's complement. The first bit of a slot lands in bit 23 of `left_out` or `right_out`.
- R4: Bits after the 24th in a slot have no effect on the output word.
- R5: A slot shorter than 24 bits is zero-filled on the LSB side, so its MSB stays at bit 23.
- R6: `pair_valid` is high for exactly one cycle per good frame, when the right slot completes (at the boundary that opens the next left slot). `left_out` and `right_out` change together in that cycle and hold their value at all other times.
- R7: In left-justified mode, a frame with fewer than 32 rising bit-clock edges (left plus right slot) raises `frame_err` for one cycle instead of `pair_valid`. Both outputs keep their previous values.
- R8: In I2S mode no frame-length check is made, and `frame_err` never rises.
- R9: During and after reset, `left_out` and `right_out` are zero and both strobes are low. No strobe fires until one complete frame has followed the first left-slot boundary.
- R10: Correct reception holds with the system clock as slow as 4 times the bit clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fmt_lj | input | 1 | Framing select: 0 I2S, 1 left-justified (static) |
| bclk_i | input | 1 | Serial bit clock (asynchronous) |
| fclk_i | input | 1 | Frame/channel clock (asynchronous) |
| sdat_i | input | 1 | Serial data line (asynchronous) |
| left_out | output | 24 | Left sample, MSB aligned |
| right_out | output | 24 | Right sample, MSB aligned |
| pair_valid | output | 1 | One-cycle strobe: new sample pair present |
| frame_err | output | 1 | One-cycle strobe: left-justified frame too short |

## Verification
Frame completion and the length check are decided in the same cycle, on the `T_R2L` transition. So a publish and an error could in principle be raised together. The bench provokes this by sweeping slot lengths on both sides of the 16-bits-per-slot limit, in both framings, with arithmetically generated words. For each frame it judges which of the two strobes fires, and that the other stays low. On an error it also checks that the previously published pair is still held on the outputs.

// File: rtl/sarx_pkg.sv
`timescale 1ns/1ps
package sarx_pkg;
    typedef enum logic [1:0] {
        ST_HUNT  = 2'd0,
        ST_LEFT  = 2'd1,
        ST_RIGHT = 2'd2
    } rx_state_t;
endpackage

// File: rtl/sarx_sync.sv
`timescale 1ns/1ps
// Two-flop synchroniser for N asynchronous lines; bit 0 also gets a rising-edge detector.
// The detector needs every high and low phase to last two or more system cycles (R10).
module sarx_sync #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] async_i,
    output logic [N-1:0] sync_o,
    output logic         rise_o
);
    genvar g;
    generate
        for (g = 0; g < N; g++) begin : g_line
            logic [1:0] stage_q;
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q <= 2'b00;
                else        stage_q <= {stage_q[0], async_i[g]};
            end
            assign sync_o[g] = stage_q[1];
        end
    endgenerate

    logic prev0_q;
    always_ff @(posedge clk) begin
        if (!rst_n) prev0_q <= 1'b0;
        else        prev0_q <= sync_o[0];
    end
    assign rise_o = sync_o[0] & ~prev0_q;
endmodule

// File: rtl/sarx_slot_track.sv
`timescale 1ns/1ps
// Finds slot boundaries. In I2S the effective channel level is the frame clock seen one
// bit-clock rise earlier, so both framings share one boundary rule (R1, R2).
module sarx_slot_track (
    input  logic clk,
    input  logic rst_n,
    input  logic fmt_lj,
    input  logic rise_i,
    input  logic fclk_i,
    output logic boundary_o,
    output logic to_left_o
);
    logic       fclk_prev_q;
    logic       lvl_prev_q;
    logic [1:0] warm_q;
    logic       chan_lvl;

    assign chan_lvl   = fmt_lj ? fclk_i : fclk_prev_q;
    assign to_left_o  = fmt_lj ? chan_lvl : ~chan_lvl;
    assign boundary_o = rise_i && (warm_q == 2'd2) && (chan_lvl != lvl_prev_q);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fclk_prev_q <= 1'b0;
            lvl_prev_q  <= 1'b0;
            warm_q      <= 2'd0;
        end else if (rise_i) begin
            fclk_prev_q <= fclk_i;
            lvl_prev_q  <= chan_lvl;
            if (warm_q != 2'd2) warm_q <= warm_q + 2'd1;
        end
    end
endmodule

// File: rtl/sarx_slot_capture.sv
`timescale 1ns/1ps
// MSB-first slot shifter: a boundary loads the new MSB and clears the rest (R5);
// bits after the W-th are dropped (R4).
module sarx_slot_capture #(
    parameter int W = 24
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         rise_i,
    input  logic         boundary_i,
    input  logic         bit_i,
    output logic [W-1:0] word_o
);
    localparam int CW = $clog2(W + 1);

    logic [W-1:0]  shreg_q;
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg_q <= '0;
            cnt_q   <= '0;
        end else if (rise_i) begin
            if (boundary_i) begin
                shreg_q <= {bit_i, {(W-1){1'b0}}};
                cnt_q   <= CW'(1);
            end else if (cnt_q < CW'(W)) begin
                for (int i = 0; i < W; i++) begin
                    if (cnt_q == CW'(W - 1 - i)) shreg_q[i] <= bit_i;
                end
                cnt_q <= cnt_q + CW'(1);
            end
        end
    end

    assign word_o = shreg_q;
endmodule

// File: rtl/serial_audio_rx.sv
`timescale 1ns/1ps
module serial_audio_rx
    import sarx_pkg::*;
#(
    parameter int SAMPLE_W    = 24,
    parameter int MIN_LJ_BITS = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                fmt_lj,
    input  logic                bclk_i,
    input  logic                fclk_i,
    input  logic                sdat_i,
    output logic [SAMPLE_W-1:0] left_out,
    output logic [SAMPLE_W-1:0] right_out,
    output logic                pair_valid,
    output logic                frame_err
);
    localparam int FCW = $clog2(MIN_LJ_BITS + 1);

    logic [2:0]          sync_v;
    logic                rise;
    logic                boundary;
    logic                to_left;
    logic [SAMPLE_W-1:0] word;

    sarx_sync #(.N(3)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({sdat_i, fclk_i, bclk_i}),
        .sync_o  (sync_v),
        .rise_o  (rise)
    );

    sarx_slot_track u_track (
        .clk        (clk),
        .rst_n      (rst_n),
        .fmt_lj     (fmt_lj),
        .rise_i     (rise),
        .fclk_i     (sync_v[1]),
        .boundary_o (boundary),
        .to_left_o  (to_left)
    );

    sarx_slot_capture #(.W(SAMPLE_W)) u_cap (
        .clk        (clk),
        .rst_n      (rst_n),
        .rise_i     (rise),
        .boundary_i (boundary),
        .bit_i      (sync_v[2]),
        .word_o     (word)
    );

    rx_state_t           state_q, state_d;
    logic                t_lock, t_l2r, t_r2l;
    logic [FCW-1:0]      frame_cnt_q;
    logic [SAMPLE_W-1:0] left_hold_q;
    logic                frame_ok;

    assign frame_ok = !fmt_lj || (frame_cnt_q >= FCW'(MIN_LJ_BITS));

    // next state and named transitions
    always_comb begin
        state_d = state_q;
        t_lock  = 1'b0;
        t_l2r   = 1'b0;
        t_r2l   = 1'b0;
        unique case (state_q)
            ST_HUNT:  if (boundary && to_left)  begin t_lock = 1'b1; state_d = ST_LEFT;  end
            ST_LEFT:  if (boundary && !to_left) begin t_l2r  = 1'b1; state_d = ST_RIGHT; end
            ST_RIGHT: if (boundary && to_left)  begin t_r2l  = 1'b1; state_d = ST_LEFT;  end
            default:  state_d = ST_HUNT;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_HUNT;
        else        state_q <= state_d;
    end

    // outputs and frame-length counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            left_out    <= '0;
            right_out   <= '0;
            pair_valid  <= 1'b0;
            frame_err   <= 1'b0;
            left_hold_q <= '0;
            frame_cnt_q <= '0;
        end else begin
            pair_valid <= 1'b0;
            frame_err  <= 1'b0;
            if (rise) begin
                if (boundary && to_left)                    frame_cnt_q <= FCW'(1);
                else if (frame_cnt_q < FCW'(MIN_LJ_BITS))   frame_cnt_q <= frame_cnt_q + FCW'(1);
            end
            if (t_l2r) left_hold_q <= word;
            if (t_r2l) begin
                if (frame_ok) begin
                    left_out   <= left_hold_q;
                    right_out  <= word;
                    pair_valid <= 1'b1;
                end else begin
                    frame_err  <= 1'b1;
                end
            end
        end
    end

    assert_valid_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        pair_valid |=> !pair_valid);
    assert_strobe_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(pair_valid && frame_err));
    assert_left_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !pair_valid |-> $stable(left_out));
    assert_right_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !pair_valid |-> $stable(right_out));
    assert_no_err_i2s_R8: assert property (@(posedge clk) disable iff (!rst_n)
        frame_err |-> fmt_lj);
    assert_hunt_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HUNT) |-> (!pair_valid && !frame_err));
endmodule

// File: tb/tb_serial_audio_rx.sv
`timescale 1ns/1ps
module tb_serial_audio_rx;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fmt_lj = 1'b0;
    logic        bclk = 1'b0;
    logic        fclk = 1'b0;
    logic        sdat = 1'b0;
    logic [23:0] left_out, right_out;
    logic        pair_valid, frame_err;

    int checks = 0;
    int errors = 0;
    int half_ns = 20;
    logic last_bit = 1'b0;

    logic [23:0] exp_l [64];
    logic [23:0] exp_r [64];
    logic        exp_e [64];
    int          exp_n [64];
    int rd = 0;
    int wr = 0;
    logic [23:0] last_l = '0;
    logic [23:0] last_r = '0;

    always #2.5 clk = ~clk;

    serial_audio_rx dut (
        .clk(clk), .rst_n(rst_n), .fmt_lj(fmt_lj),
        .bclk_i(bclk), .fclk_i(fclk), .sdat_i(sdat),
        .left_out(left_out), .right_out(right_out),
        .pair_valid(pair_valid), .frame_err(frame_err)
    );

    function automatic logic wbit(input logic [23:0] w, input int j);
        return (j < 24) ? w[23 - j] : 1'b0;
    endfunction

    function automatic logic [23:0] trunc(input logic [23:0] w, input int n);
        if (n >= 24) return w;
        return w & ~((24'h1 << (24 - n)) - 24'h1);
    endfunction

    task automatic rise_bit(input logic lvl, input logic d);
        fclk = lvl; sdat = d;
        #(half_ns); bclk = 1'b1;
        #(half_ns); bclk = 1'b0;
    endtask

    task automatic send_slot(input logic lvl, input logic [23:0] w, input int n);
        for (int j = 0; j < n; j++) begin
            logic d;
            if (fmt_lj) d = wbit(w, j);
            else        d = (j == 0) ? last_bit : wbit(w, j - 1);
            rise_bit(lvl, d);
        end
        last_bit = wbit(w, n - 1);
    endtask

    task automatic send_frame(input logic [23:0] l, input logic [23:0] r, input int n);
        send_slot(fmt_lj, l, n);
        send_slot(~fmt_lj, r, n);
        exp_l[wr] = trunc(l, n);
        exp_r[wr] = trunc(r, n);
        exp_e[wr] = fmt_lj && (2 * n < 32);
        exp_n[wr] = n;
        wr++;
    endtask

    task automatic start_group(input logic fmt, input int half);
        rst_n = 1'b0; fmt_lj = fmt; half_ns = half;
        bclk = 1'b0; fclk = ~fmt; sdat = 1'b0; last_bit = 1'b0;
        rd = 0; wr = 0; last_l = '0; last_r = '0;
        #40;
        checks++;   // R9 reset state
        if (left_out !== 24'h0 || right_out !== 24'h0 || pair_valid !== 1'b0 || frame_err !== 1'b0) begin
            errors++;
            $display("FAIL R9 reset state got l=%h r=%h v=%0b e=%0b expected all zero",
                     left_out, right_out, pair_valid, frame_err);
        end
        #20 rst_n = 1'b1;
        #20;
        send_slot(~fmt, 24'h0, 4);   // idle slot on the right-channel level
    endtask

    task automatic end_group;
        send_slot(fmt_lj, 24'h0, 2); // opens a left slot, closing the last frame
        #(half_ns * 8);
        checks++;
        if (rd != wr) begin
            errors++;
            $display("FAIL R1/R2/R6 fmt=%0b strobes seen %0d expected %0d", fmt_lj, rd, wr);
        end
    endtask

    // strobe monitor, sampled on the falling clock edge
    always @(negedge clk) begin
        if (rst_n && (pair_valid || frame_err)) begin
            if (rd >= wr) begin
                checks++; errors++;
                $display("FAIL R6/R9 unexpected strobe v=%0b e=%0b expected none", pair_valid, frame_err);
            end else begin
                checks++;
                if (frame_err !== exp_e[rd] || pair_valid !== !exp_e[rd]) begin
                    errors++;
                    $display("FAIL R7/R8 fmt=%0b n=%0d got v=%0b e=%0b expected e=%0b",
                             fmt_lj, exp_n[rd], pair_valid, frame_err, exp_e[rd]);
                end
                if (exp_e[rd]) begin
                    checks++;
                    if (left_out !== last_l || right_out !== last_r) begin
                        errors++;
                        $display("FAIL R7 hold on error got %h/%h expected %h/%h",
                                 left_out, right_out, last_l, last_r);
                    end
                end else begin
                    checks += 2;
                    if (left_out !== exp_l[rd]) begin
                        errors++;
                        $display("FAIL R1/R2/R3/R4/R5 fmt=%0b n=%0d left got %h expected %h",
                                 fmt_lj, exp_n[rd], left_out, exp_l[rd]);
                    end
                    if (right_out !== exp_r[rd]) begin
                        errors++;
                        $display("FAIL R1/R2/R3/R4/R5 fmt=%0b n=%0d right got %h expected %h",
                                 fmt_lj, exp_n[rd], right_out, exp_r[rd]);
                    end
                    last_l = exp_l[rd];
                    last_r = exp_r[rd];
                end
                rd++;
            end
        end
    end

    initial begin
        #1_000_000;
        errors++;
        $display("FAIL watchdog expired expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int lens [8];
        lens = '{2, 8, 15, 16, 20, 24, 25, 32};
        for (int f = 0; f < 2; f++) begin
            start_group(f[0], 20);
            send_frame(24'h800000, 24'h7FFFFF, 24);   // R3 extremes
            for (int i = 0; i < 8; i++) begin
                for (int k = 0; k < 2; k++) begin
                    logic [23:0] l, r;
                    l = 24'(lens[i] * 24'h0B3C5D + k * 24'h51F00F + f * 24'h700001);
                    r = ~l ^ 24'h0F0F0F;
                    send_frame(l, r, lens[i]);   // R4 (n>24), R5 (n<24), R7 (n<16, LJ)
                end
            end
            end_group();
        end
        // R10: bit clock at exactly a quarter of the system clock
        start_group(1'b1, 10);
        for (int k = 0; k < 4; k++) begin
            send_frame(24'(24'hA5C3E1 + k * 24'h111111), 24'(24'h3C5A69 ^ (k * 24'h0F1E2D)), 24);
        end
        send_frame(24'h123456, 24'hFEDCBA, 16);
        end_group();
        start_group(1'b0, 10);
        for (int k = 0; k < 3; k++) begin
            send_frame(24'(24'h5A5A5A + k * 24'h010203), 24'(24'hC0FFEE - k), 24);
        end
        end_group();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule